// File: doc/BRIEF.md
# Quasi-Bidirectional I2C Port Expander

This block is an I2C slave that controls an eight-bit port. It samples SCL and SDA with the system clock and drives SDA only through an open-drain enable. It answers one 7-bit address. The upper four bits of that address are fixed at binary 0100, and the three strap inputs supply the lower three, so up to eight of these blocks can share one bus.

Each port bit is a latch bit. A latch bit of 0 pulls its pin strongly low. A latch bit of 1 leaves the pin weakly high, so something outside can pull it low. There is no separate direction setting: to use a pin as an input, write a 1 to its latch bit.

In a write transfer, every data byte the master sends is acknowledged and replaces the latch contents. In a read transfer, each byte returned is a fresh sample of the pin levels, not the latch contents. The read goes on for as long as the master acknowledges. After START, the block honours no STOP or repeated START until nine SCL cycles have passed.

Top module: `qbx_port_expander`

## Requirements
- R1: After reset, `latch_o` is 8'hFF and `sda_oe_o` is 0.
- R2: The block acknowledges an address byte whose bits 7..1 are {4'b0100, strap_i[2:0]}. Acknowledging means `sda_oe_o` is 1 during the ninth SCL high period. Bit 0 of that byte is R/W: 0 selects write and 1 selects read.
- R3: After an address byte that does not match, the block gives no acknowledge. It also ignores every later bit until the next honoured START, so `latch_o` keeps its value and `sda_oe_o` stays 0.
- R4: In a write transfer, each data byte, received MSB first, is acknowledged and stored so that `latch_o[k]` equals data bit k. Each following byte replaces the previous one.
- R5: A new latch value appears during the SCL high period of the acknowledge bit of the byte that carried it. During the eighth data bit, `latch_o` still shows the old value.
- R6: In a read transfer, each byte is sent MSB first. It holds the `pin_i` levels captured on the SCL falling edge just before the byte's first bit, so each byte of a multi-byte read is a new sample.
- R7: When the master does not acknowledge a read byte, the block releases SDA and drives nothing on the following SCL clocks.
- R8: A pin whose latch bit is 1 reads back the level applied from outside. A pin whose latch bit is 0 reads back 0.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START begins a new address phase. After an honoured STOP, bytes clocked without a new START have no effect.
- R10: A STOP or repeated START that arrives before the ninth SCL rising edge after a START is ignored, and the transfer continues.
- R11: A pulse on SCL or SDA that lasts fewer than three system clocks after synchronisation has no effect.
- R12: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; also acts as power-on reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 3 | Lower three address bits |
| pin_i | input | 8 | Sensed level of each port pin |
| latch_o | output | 8 | Port latch: 0 drives the pin low, 1 leaves it weakly high |

## Verification
The assertions assume the master follows the bus rules. It changes SDA only while SCL is low, except for deliberate START and STOP conditions. It never makes a STOP or START while the slave holds SDA low, and it keeps each SCL level much longer than the filter delay. The bench master waits a quarter bit after every SCL falling edge before it moves SDA, which keeps both filtered lines in the same order as the raw lines. The only violations the bench creates on purpose are filter glitches of two clocks and an early STOP, which R11 and R10 require the block to ignore.

// File: rtl/qbx_pkg.sv
package qbx_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK
    } qbx_state_e;

    typedef struct packed {
        qbx_state_e             state;
        logic [BIT_CNT_W-1:0]   bitcnt;
        logic [BYTE_W-1:0]      shreg;
        logic [BYTE_W-1:0]      txreg;
        logic                   rw;
        logic                   oe;
        logic                   mack;
    } qbx_ctrl_t;

endpackage

// File: rtl/qbx_line_filter.sv
module qbx_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);

    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic [FILT_LEN-1:0]    hist_d, hist_q;
    logic                   filt_d, filt_q;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], raw_i};
        hist_d = {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
        filt_d = filt_q;
        if (&hist_q) begin
            filt_d = 1'b1;
        end else if (~|hist_q) begin
            filt_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            filt_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            hist_q <= hist_d;
            filt_q <= filt_d;
        end
    end

    assign filt_o = filt_q;

    AST_FILTER_HOLDS_ON_MIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_q != {FILT_LEN{1'b1}} && hist_q != {FILT_LEN{1'b0}}) |=> $stable(filt_q)); // R11

endmodule

// File: rtl/qbx_bus_cond.sv
module qbx_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f_i,
    input  logic sda_f_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_prev_d, scl_prev_q;
    logic sda_prev_d, sda_prev_q;

    always_comb begin
        scl_prev_d = scl_f_i;
        sda_prev_d = sda_f_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_rise_o = scl_f_i & ~scl_prev_q;
    assign scl_fall_o = ~scl_f_i & scl_prev_q;
    assign start_o    = scl_f_i & scl_prev_q & sda_prev_q & ~sda_f_i;
    assign stop_o     = scl_f_i & scl_prev_q & ~sda_prev_q & sda_f_i;

endmodule

// File: rtl/qbx_port_latch.sv
module qbx_port_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (load_i) begin
            bits_d = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '1;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign q_o = bits_q;

endmodule

// File: rtl/qbx_port_expander.sv
module qbx_port_expander
    import qbx_pkg::*;
#(
    parameter int         GUARD_MAX   = 9,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3,
    parameter logic [3:0] ADDR_FIXED  = 4'b0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        strap_i,
    input  logic [BYTE_W-1:0] pin_i,
    output logic [BYTE_W-1:0] latch_o
);

    localparam int GUARD_W = $clog2(GUARD_MAX + 1);
    localparam logic [GUARD_W-1:0] GUARD_TOP = GUARD_W'(GUARD_MAX);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W);

    // Line conditioning: index 0 is SCL, index 1 is SDA
    logic [1:0] raw_lines;
    logic [1:0] filt_lines;
    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        qbx_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[g]),
            .filt_o (filt_lines[g])
        );
    end

    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_w, stop_w;
    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    qbx_bus_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_f_i    (scl_f),
        .sda_f_i    (sda_f),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_w),
        .stop_o     (stop_w)
    );

    qbx_ctrl_t           r_d, r_q;
    logic [GUARD_W-1:0]  guard_d, guard_q;
    logic                start_ok, stop_ok, addr_hit;
    logic                latch_load;

    assign start_ok = start_w & (guard_q == GUARD_TOP);
    assign stop_ok  = stop_w  & (guard_q == GUARD_TOP);
    assign addr_hit = (r_q.shreg[BYTE_W-1:1] == {ADDR_FIXED, strap_i});

    always_comb begin
        r_d        = r_q;
        guard_d    = guard_q;
        latch_load = 1'b0;

        if (scl_rise && guard_q != GUARD_TOP) begin
            guard_d = guard_q + GUARD_W'(1);
        end

        if (start_ok) begin
            r_d.state  = ST_ADDR;
            r_d.bitcnt = '0;
            r_d.oe     = 1'b0;
            guard_d    = '0;
        end else if (stop_ok) begin
            r_d.state = ST_IDLE;
            r_d.oe    = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        r_d.shreg  = {r_q.shreg[BYTE_W-2:0], sda_f};
                        r_d.bitcnt = r_q.bitcnt + BIT_CNT_W'(1);
                    end else if (scl_fall && r_q.bitcnt == LAST_BIT) begin
                        if (addr_hit) begin
                            r_d.state = ST_ADDR_ACK;
                            r_d.oe    = 1'b1;
                            r_d.rw    = r_q.shreg[0];
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        r_d.bitcnt = '0;
                        if (r_q.rw) begin
                            r_d.state = ST_RD_DATA;
                            r_d.txreg = pin_i;
                            r_d.oe    = ~pin_i[BYTE_W-1];
                        end else begin
                            r_d.state = ST_WR_DATA;
                            r_d.oe    = 1'b0;
                        end
                    end
                end
                ST_WR_DATA: begin
                    if (scl_rise) begin
                        r_d.shreg  = {r_q.shreg[BYTE_W-2:0], sda_f};
                        r_d.bitcnt = r_q.bitcnt + BIT_CNT_W'(1);
                    end else if (scl_fall && r_q.bitcnt == LAST_BIT) begin
                        r_d.state = ST_WR_ACK;
                        r_d.oe    = 1'b1;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_rise) begin
                        latch_load = 1'b1;
                    end else if (scl_fall) begin
                        r_d.state  = ST_WR_DATA;
                        r_d.bitcnt = '0;
                        r_d.oe     = 1'b0;
                    end
                end
                ST_RD_DATA: begin
                    if (scl_rise) begin
                        r_d.bitcnt = r_q.bitcnt + BIT_CNT_W'(1);
                    end else if (scl_fall) begin
                        if (r_q.bitcnt == LAST_BIT) begin
                            r_d.state = ST_RD_ACK;
                            r_d.oe    = 1'b0;
                        end else begin
                            r_d.txreg = {r_q.txreg[BYTE_W-2:0], 1'b1};
                            r_d.oe    = ~r_q.txreg[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        r_d.mack = ~sda_f;
                    end else if (scl_fall) begin
                        if (r_q.mack) begin
                            r_d.state  = ST_RD_DATA;
                            r_d.bitcnt = '0;
                            r_d.txreg  = pin_i;
                            r_d.oe     = ~pin_i[BYTE_W-1];
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                default: begin
                    r_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.bitcnt <= '0;
            r_q.shreg  <= '0;
            r_q.txreg  <= '1;
            r_q.rw     <= 1'b0;
            r_q.oe     <= 1'b0;
            r_q.mack   <= 1'b0;
            guard_q    <= GUARD_TOP;
        end else begin
            r_q     <= r_d;
            guard_q <= guard_d;
        end
    end

    qbx_port_latch #(
        .WIDTH (BYTE_W)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (latch_load),
        .data_i (r_q.shreg),
        .q_o    (latch_o)
    );

    assign sda_oe_o = r_q.oe;

    AST_LATCH_ONLY_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_WR_ACK) |=> $stable(latch_o)); // R5

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_f); // R12

    AST_EARLY_STOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_w && guard_q != GUARD_TOP && r_q.state != ST_IDLE) |=> (r_q.state != ST_IDLE)); // R10

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE) |-> !sda_oe_o); // R3

    AST_NO_ACK_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ADDR && scl_fall && r_q.bitcnt == LAST_BIT && !addr_hit)
        |=> (!sda_oe_o && r_q.state == ST_IDLE)); // R3

endmodule

// File: tb/qbx_port_expander_test.sv
module qbx_port_expander_test;

    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'd0;
    logic [7:0] ext_low = 8'h00;
    logic       sda_oe;
    logic [7:0] latch;
    logic       sda_line;
    logic [7:0] pins;

    int checks = 0;
    int fails = 0;
    int oe_viol = 0;
    logic prev_oe = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign pins     = latch & ~ext_low;

    qbx_port_expander uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .strap_i  (strap),
        .pin_i    (pins),
        .latch_o  (latch)
    );

    // R12 monitor: SDA enable may move only while SCL is low
    always @(negedge clk) begin
        if (rst_n && (sda_oe != prev_oe) && scl_m) oe_viol++;
        prev_oe <= sda_oe;
    end

    localparam logic [2:0] V_STRAP [6] = '{3'd0, 3'd7, 3'd5, 3'd2, 3'd3, 3'd6};
    localparam logic [7:0] V_DATA  [6] = '{8'hFF, 8'h00, 8'hA5, 8'h3C, 8'h81, 8'h7E};
    localparam logic [7:0] V_EXT   [6] = '{8'h00, 8'hFF, 8'h0F, 8'hF0, 8'h55, 8'h18};

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic qtr(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qtr(1);
        scl_m = 1'b1; qtr(1);
        sda_m = 1'b0; qtr(1);
        scl_m = 1'b0; qtr(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qtr(1);
        scl_m = 1'b1; qtr(1);
        sda_m = 1'b1; qtr(2);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; qtr(1);
        scl_m = 1'b1; qtr(2);
        scl_m = 1'b0; qtr(1);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; qtr(1);
        scl_m = 1'b1; qtr(1);
        b = sda_line; qtr(1);
        scl_m = 1'b0; qtr(1);
    endtask

    task automatic ack_phase(output logic ack, output logic [7:0] post);
        sda_m = 1'b1; qtr(1);
        scl_m = 1'b1; qtr(1);
        ack = ~sda_line;
        post = latch;
        qtr(1);
        scl_m = 1'b0; qtr(1);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack,
                              output logic [7:0] pre, output logic [7:0] post);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        pre = latch;
        ack_phase(ack, post);
    endtask

    task automatic read_byte(input logic mack, input logic [7:0] next_ext, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        ext_low = next_ext;
        send_bit(~mack);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] pre, post, rd, keep;

        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R1 reset state
        chk(latch == 8'hFF, "R1 latch", latch, 8'hFF);
        chk(sda_oe == 1'b0, "R1 sda_oe", {7'd0, sda_oe}, 8'h00);

        // Vector table: write, then read back through pins
        for (int v = 0; v < 6; v++) begin
            strap = V_STRAP[v];
            bus_start();
            write_byte({4'b0100, V_STRAP[v], 1'b0}, ack, pre, post);
            chk(ack, "R2 write addr ack", {7'd0, ack}, 8'h01);
            write_byte(V_DATA[v], ack, pre, post);
            chk(ack && post == V_DATA[v], "R4 table write", post, V_DATA[v]);
            bus_stop();
            ext_low = V_EXT[v];
            bus_start();
            write_byte({4'b0100, V_STRAP[v], 1'b1}, ack, pre, post);
            chk(ack, "R2 read addr ack", {7'd0, ack}, 8'h01);
            read_byte(1'b0, V_EXT[v], rd);
            chk(rd == (V_DATA[v] & ~V_EXT[v]), "R6 R8 table read", rd, V_DATA[v] & ~V_EXT[v]);
            bus_stop();
        end
        ext_low = 8'h00;

        // R3 address mismatch
        strap = 3'd3;
        keep = latch;
        bus_start();
        write_byte({4'b0100, 3'd4, 1'b0}, ack, pre, post);
        chk(!ack, "R3 mismatch nack", {7'd0, ack}, 8'h00);
        write_byte(8'h00, ack, pre, post);
        chk(!ack && latch == keep, "R3 ignored data", latch, keep);
        bus_stop();
        bus_start();
        write_byte({4'b1100, 3'd3, 1'b0}, ack, pre, post);
        chk(!ack, "R3 upper bits mismatch", {7'd0, ack}, 8'h00);
        bus_stop();

        // R4 / R5 multi-byte write, then R9 repeated start into read
        bus_start();
        write_byte({4'b0100, 3'd3, 1'b0}, ack, pre, post);
        write_byte(8'h12, ack, pre, post);
        chk(ack && post == 8'h12, "R4 byte1", post, 8'h12);
        write_byte(8'h34, ack, pre, post);
        chk(pre == 8'h12, "R5 old before ack", pre, 8'h12);
        chk(ack && post == 8'h34, "R5 new at ack clock", post, 8'h34);
        write_byte(8'h56, ack, pre, post);
        chk(ack && post == 8'h56, "R4 byte3", post, 8'h56);
        bus_start();
        write_byte({4'b0100, 3'd3, 1'b1}, ack, pre, post);
        chk(ack, "R9 repeated start ack", {7'd0, ack}, 8'h01);
        read_byte(1'b0, 8'h00, rd);
        chk(rd == 8'h56, "R9 read after restart", rd, 8'h56);
        bus_stop();

        // R6 / R7 multi-byte read with fresh samples, then NACK release
        bus_start();
        write_byte({4'b0100, 3'd3, 1'b0}, ack, pre, post);
        write_byte(8'hFF, ack, pre, post);
        bus_stop();
        ext_low = 8'h0F;
        bus_start();
        write_byte({4'b0100, 3'd3, 1'b1}, ack, pre, post);
        read_byte(1'b1, 8'hC3, rd);
        chk(rd == 8'hF0, "R6 read byte1", rd, 8'hF0);
        read_byte(1'b0, 8'h00, rd);
        chk(rd == 8'h3C, "R6 fresh sample byte2", rd, 8'h3C);
        ext_low = 8'hFF;
        read_byte(1'b0, 8'hFF, rd);
        chk(rd == 8'hFF, "R7 released after nack", rd, 8'hFF);
        bus_stop();
        ext_low = 8'h00;

        // R9 stop honoured: bytes without START have no effect
        keep = latch;
        write_byte({4'b0100, 3'd3, 1'b0}, ack, pre, post);
        chk(!ack, "R9 no ack after stop", {7'd0, ack}, 8'h00);
        write_byte(8'h00, ack, pre, post);
        chk(latch == keep, "R9 latch kept after stop", latch, keep);

        // R10 early STOP within nine clocks is ignored
        bus_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        sda_m = 1'b0; qtr(1);
        scl_m = 1'b1; qtr(1);
        sda_m = 1'b1; qtr(1);
        scl_m = 1'b0; qtr(1);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        ack_phase(ack, post);
        chk(ack, "R10 addr ack after early stop", {7'd0, ack}, 8'h01);
        write_byte(8'h99, ack, pre, post);
        chk(ack && post == 8'h99, "R10 write continues", post, 8'h99);
        bus_stop();

        // R11 glitches on SCL and SDA
        bus_start();
        write_byte({4'b0100, 3'd3, 1'b0}, ack, pre, post);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 8'h5A >> i;
            if (i == 5) begin
                repeat (3) @(negedge clk);
                scl_m = 1'b1; repeat (2) @(negedge clk);
                scl_m = 1'b0; repeat (Q - 5) @(negedge clk);
            end else begin
                qtr(1);
            end
            scl_m = 1'b1;
            if (i == 6) begin
                qtr(1);
                sda_m = 1'b0; repeat (2) @(negedge clk);
                sda_m = 1'b1; repeat (Q - 2) @(negedge clk);
            end else begin
                qtr(2);
            end
            scl_m = 1'b0; qtr(1);
        end
        ack_phase(ack, post);
        chk(ack && post == 8'h5A, "R11 glitches ignored", post, 8'h5A);
        bus_stop();

        chk(oe_viol == 0, "R12 sda_oe moved with scl high", 8'(oe_viol), 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule